// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page translations for a 32-bit address space divided into 4 KB pages. A requester presents a virtual address, the identifier of the current address space and the kind of access (read, write or instruction fetch). One cycle later the block answers with a hit and the physical address, with a protection fault when the cached permissions forbid that access, or with a miss.

On a miss the block raises a walk request that carries the missing page number and address-space identifier. An external table walker answers with a fill. The block writes the fill into an entry and the requester repeats the access, which then hits. Entries are tagged with an address-space identifier and may be marked global, so a change of address space needs no flush. Maintenance commands drop a single page in every address space, drop every non-global entry of one address space, or empty the whole cache. A new translation goes into the lowest-numbered free entry. When no entry is free it goes into the entry named by a round-robin pointer.

Top module: `xlat_cache`

## Requirements
- R1: After reset no response and no walk request is raised, and every entry is empty, so any lookup misses.
- R2: A lookup presented in one cycle is answered in the next cycle, and `rsp_valid` is high for exactly that one cycle.
- R3: On a hit with permission, `rsp_hit` is 1 and `rsp_paddr` equals the entry's frame number shifted left by 12, ORed with bits 11:0 of the virtual address.
- R4: On a miss, `rsp_hit` and `rsp_fault` are 0, `walk_req` is 1, `walk_vpn` is bits 31:12 of the address and `walk_asid` is the lookup identifier. A repeat of the access after the matching fill hits.
- R5: Access kind encoding: 0 read, 1 write, 2 fetch, 3 reserved. Permission field: bit 0 read, bit 1 write, bit 2 fetch. A hit whose permission bit for the kind is clear, or any hit with kind 3, gives `rsp_fault`=1, `rsp_hit`=0, `rsp_paddr`=0 and no walk request.
- R6: An entry matches only when it is valid, its page number equals the lookup page number, and either its identifier equals the lookup identifier or it is marked global.
- R7: An invalidate command empties every entry with the given page number, whatever its identifier or global mark.
- R8: A flush with `flush_all`=1 empties every entry. A flush with `flush_all`=0 empties only the non-global entries whose identifier equals `flush_asid`.
- R9: When an invalidate or flush falls in the same cycle as a fill, the fill is discarded. A lookup always sees the table as it was before updates in its own cycle.
- R10: A fill goes into the lowest-numbered empty entry. If none is empty it goes into the entry named by the round-robin pointer. The pointer advances by one, wrapping at the entry count, on every accepted fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_asid | input | 8 | Current address-space identifier |
| lk_kind | input | 2 | Access kind (0 read, 1 write, 2 fetch, 3 reserved) |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_fault | output | 1 | Translation found but access forbidden |
| rsp_paddr | output | 32 | Physical address on a permitted hit, else 0 |
| walk_req | output | 1 | Request to the table walker (miss) |
| walk_vpn | output | 20 | Page number to walk |
| walk_asid | output | 8 | Identifier to walk |
| fill_valid | input | 1 | Fill from the walker |
| fill_vpn | input | 20 | Page number of the fill |
| fill_asid | input | 8 | Identifier of the fill |
| fill_pfn | input | 20 | Frame number of the fill |
| fill_perm | input | 3 | Permissions (bit 0 read, 1 write, 2 fetch) |
| fill_global | input | 1 | Entry matches every identifier |
| inv_valid | input | 1 | Invalidate one page number |
| inv_vpn | input | 20 | Page number to invalidate |
| flush_valid | input | 1 | Flush command |
| flush_all | input | 1 | 1: flush all; 0: flush one identifier |
| flush_asid | input | 8 | Identifier for a selective flush |

## Verification
A fill can arrive in the same cycle as an invalidate or a flush, and a lookup can arrive in the same cycle as a fill. The bench drives a fill together with an unrelated invalidate and judges the result by a later lookup of the filled page, which must miss. It also drives a lookup together with the fill for the same page: that answer must be a miss, and the next lookup must hit. The replacement test fills the table, frees one entry in the middle and then counts accepted fills to predict which entry the round-robin pointer displaces.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int ASID_W    = 8;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PFN_W     = PA_W - PAGE_BITS;
    localparam int PERM_W    = 3;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic              vld;
        logic              glb;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
    } xlat_ent_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N = 64
) (
    input  xlat_ent_t [N-1:0]  ents,
    input  logic [VPN_W-1:0]   vpn,
    input  logic [ASID_W-1:0]  asid,
    output logic               hit_any,
    output xlat_ent_t          hit_ent
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].vld && (ents[g].vpn == vpn) &&
                            (ents[g].glb || (ents[g].asid == asid));
    end

    // Lowest index wins if the table ever holds duplicates.
    always_comb begin
        hit_ent = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_ent = ents[i];
        end
    end

    assign hit_any = |hit_vec;
endmodule

// File: rtl/xlat_maint.sv
module xlat_maint
    import xlat_pkg::*;
#(
    parameter int N = 64
) (
    input  xlat_ent_t [N-1:0]  ents,
    input  logic               inv_valid,
    input  logic [VPN_W-1:0]   inv_vpn,
    input  logic               flush_valid,
    input  logic               flush_all,
    input  logic [ASID_W-1:0]  flush_asid,
    output logic [N-1:0]       kill
);
    for (genvar g = 0; g < N; g++) begin : g_kill
        logic by_page;
        logic by_space;
        assign by_page  = inv_valid && (ents[g].vpn == inv_vpn);
        assign by_space = flush_valid &&
                          (flush_all || (!ents[g].glb && ents[g].asid == flush_asid));
        assign kill[g]  = by_page || by_space;
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vld,
    input  logic [IW-1:0] rr_ptr,
    output logic [IW-1:0] slot
);
    always_comb begin
        slot = rr_ptr;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) slot = IW'(i);
        end
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_valid,
    input  logic [VA_W-1:0]       lk_vaddr,
    input  logic [ASID_W-1:0]     lk_asid,
    input  logic [1:0]            lk_kind,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_fault,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  walk_req,
    output logic [VPN_W-1:0]      walk_vpn,
    output logic [ASID_W-1:0]     walk_asid,
    input  logic                  fill_valid,
    input  logic [VPN_W-1:0]      fill_vpn,
    input  logic [ASID_W-1:0]     fill_asid,
    input  logic [PFN_W-1:0]      fill_pfn,
    input  logic [PERM_W-1:0]     fill_perm,
    input  logic                  fill_global,
    input  logic                  inv_valid,
    input  logic [VPN_W-1:0]      inv_vpn,
    input  logic                  flush_valid,
    input  logic                  flush_all,
    input  logic [ASID_W-1:0]     flush_asid
);
    localparam int PTR_W = $clog2(ENTRIES);

    typedef struct packed {
        xlat_ent_t [ENTRIES-1:0] ents;
        logic [PTR_W-1:0]        ptr;
        logic                    rsp_valid;
        logic                    rsp_hit;
        logic                    rsp_fault;
        logic [PA_W-1:0]         rsp_paddr;
        logic                    walk_req;
        logic [VPN_W-1:0]        walk_vpn;
        logic [ASID_W-1:0]       walk_asid;
    } st_t;

    st_t st_d, st_q;

    logic [VPN_W-1:0]   lk_vpn;
    logic               hit_any;
    xlat_ent_t          hit_ent;
    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] vld_vec;
    logic [PTR_W-1:0]   slot;
    logic               perm_ok;

    assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        assign vld_vec[g] = st_q.ents[g].vld;
    end

    xlat_match #(.N(ENTRIES)) i_match (
        .ents    (st_q.ents),
        .vpn     (lk_vpn),
        .asid    (lk_asid),
        .hit_any (hit_any),
        .hit_ent (hit_ent)
    );

    xlat_maint #(.N(ENTRIES)) i_maint (
        .ents        (st_q.ents),
        .inv_valid   (inv_valid),
        .inv_vpn     (inv_vpn),
        .flush_valid (flush_valid),
        .flush_all   (flush_all),
        .flush_asid  (flush_asid),
        .kill        (kill)
    );

    xlat_victim #(.N(ENTRIES), .IW(PTR_W)) i_victim (
        .vld    (vld_vec),
        .rr_ptr (st_q.ptr),
        .slot   (slot)
    );

    always_comb begin
        case (acc_kind_e'(lk_kind))
            ACC_READ:  perm_ok = hit_ent.perm[0];
            ACC_WRITE: perm_ok = hit_ent.perm[1];
            ACC_EXEC:  perm_ok = hit_ent.perm[2];
            default:   perm_ok = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;

        // Lookup answer, registered for the next cycle.
        st_d.rsp_valid = lk_valid;
        st_d.rsp_hit   = 1'b0;
        st_d.rsp_fault = 1'b0;
        st_d.rsp_paddr = '0;
        st_d.walk_req  = 1'b0;
        st_d.walk_vpn  = lk_vpn;
        st_d.walk_asid = lk_asid;
        if (lk_valid) begin
            if (hit_any) begin
                if (perm_ok) begin
                    st_d.rsp_hit   = 1'b1;
                    st_d.rsp_paddr = {hit_ent.pfn, lk_vaddr[PAGE_BITS-1:0]};
                end else begin
                    st_d.rsp_fault = 1'b1;
                end
            end else begin
                st_d.walk_req = 1'b1;
            end
        end

        // Maintenance wins over a fill in the same cycle.
        if (inv_valid || flush_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (kill[i]) st_d.ents[i].vld = 1'b0;
            end
        end else if (fill_valid) begin
            st_d.ents[slot].vld  = 1'b1;
            st_d.ents[slot].glb  = fill_global;
            st_d.ents[slot].asid = fill_asid;
            st_d.ents[slot].vpn  = fill_vpn;
            st_d.ents[slot].pfn  = fill_pfn;
            st_d.ents[slot].perm = fill_perm;
            if (st_q.ptr == PTR_W'(ENTRIES - 1)) st_d.ptr = '0;
            else                                 st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_fault = st_q.rsp_fault;
    assign rsp_paddr = st_q.rsp_paddr;
    assign walk_req  = st_q.walk_req;
    assign walk_vpn  = st_q.walk_vpn;
    assign walk_asid = st_q.walk_asid;

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid));

    // R4
    walk_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (rsp_valid && !rsp_hit && !rsp_fault));

    // R5
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (!rsp_hit && rsp_paddr == '0 && !walk_req));

    // R8
    flush_all_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_all) |=> (vld_vec == '0));

    // R9
    maint_beats_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((inv_valid || flush_valid) && fill_valid) |=>
            ($countones(vld_vec) <= $past($countones(vld_vec))));

    // R10
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_valid && !flush_valid) |=>
            (st_q.ptr == (($past(st_q.ptr) == PTR_W'(ENTRIES - 1)) ? '0 : $past(st_q.ptr) + 1'b1)));
endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic [1:0]  lk_kind = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, walk_req;
    logic [31:0] rsp_paddr;
    logic [19:0] walk_vpn;
    logic [7:0]  walk_asid;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic [2:0]  fill_perm = '0;
    logic        fill_global = 1'b0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush_valid = 1'b0;
    logic        flush_all = 1'b0;
    logic [7:0]  flush_asid = '0;

    int checks = 0;
    int errors = 0;
    int nfills = 0;

    logic        r_valid, r_hit, r_fault, r_walk;
    logic [31:0] r_paddr;
    logic [19:0] r_wvpn;
    logic [7:0]  r_wasid;

    always #2 clk = ~clk;

    xlat_cache i_xlat_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_kind(lk_kind),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_asid(walk_asid),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_global(fill_global),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn),
        .flush_valid(flush_valid), .flush_all(flush_all), .flush_asid(flush_asid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sample();
        r_valid = rsp_valid; r_hit = rsp_hit; r_fault = rsp_fault;
        r_paddr = rsp_paddr; r_walk = walk_req; r_wvpn = walk_vpn; r_wasid = walk_asid;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_kind = kind;
        @(negedge clk);
        lk_valid = 1'b0;
        sample();
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] asid,
                        input logic [19:0] pfn, input logic [2:0] perm, input logic glb);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid;
        fill_pfn = pfn; fill_perm = perm; fill_global = glb;
        @(negedge clk);
        fill_valid = 1'b0;
        nfills++;
    endtask

    task automatic inval(input logic [19:0] vpn);
        @(negedge clk);
        inv_valid = 1'b1; inv_vpn = vpn;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic flush(input logic all, input logic [7:0] asid);
        @(negedge clk);
        flush_valid = 1'b1; flush_all = all; flush_asid = asid;
        @(negedge clk);
        flush_valid = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input logic [31:0] va, input logic [7:0] asid,
                              input logic [1:0] kind, input logic [31:0] pa);
        lookup(va, asid, kind);
        chk({tag, " hit"}, 32'(r_hit), 32'd1);
        chk({tag, " paddr"}, r_paddr, pa);
    endtask

    task automatic expect_miss(input string tag, input logic [31:0] va, input logic [7:0] asid);
        lookup(va, asid, 2'd0);
        chk({tag, " miss"}, {29'd0, r_hit, r_fault, r_walk}, 32'b001);
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 walk_req after reset", 32'(walk_req), 32'd0);
        expect_miss("R1 empty table", 32'h0000_1000, 8'd0);
    endtask

    task automatic t_miss_fill();
        lookup(32'h0001_2345, 8'd3, 2'd0);
        chk("R2 rsp_valid", 32'(r_valid), 32'd1);
        chk("R4 miss flags", {29'd0, r_hit, r_fault, r_walk}, 32'b001);
        chk("R4 walk_vpn", 32'(r_wvpn), 32'h00012);
        chk("R4 walk_asid", 32'(r_wasid), 32'd3);
        @(negedge clk);
        chk("R2 rsp_valid one cycle", 32'(rsp_valid), 32'd0);
        fill(20'h00012, 8'd3, 20'hABCDE, 3'b001, 1'b0);
        expect_hit("R3 R4 retry", 32'h0001_2345, 8'd3, 2'd0, 32'hABCD_E345);
    endtask

    task automatic t_perm();
        lookup(32'h0001_2FFF, 8'd3, 2'd1);
        chk("R5 write on read-only", {29'd0, r_hit, r_fault, r_walk}, 32'b010);
        chk("R5 fault paddr", r_paddr, 32'd0);
        fill(20'h00033, 8'd3, 20'h00777, 3'b100, 1'b0);
        expect_hit("R5 fetch allowed", 32'h0003_3010, 8'd3, 2'd2, 32'h0077_7010);
        lookup(32'h0003_3010, 8'd3, 2'd0);
        chk("R5 read on fetch-only", 32'(r_fault), 32'd1);
        fill(20'h00044, 8'd3, 20'h00888, 3'b111, 1'b0);
        lookup(32'h0004_4000, 8'd3, 2'd3);
        chk("R5 reserved kind", {29'd0, r_hit, r_fault, r_walk}, 32'b010);
    endtask

    task automatic t_asid();
        expect_miss("R6 other asid", 32'h0001_2345, 8'd4);
        fill(20'h00050, 8'd1, 20'h11111, 3'b111, 1'b1);
        expect_hit("R6 global other asid", 32'h0005_0ABC, 8'd9, 2'd1, 32'h1111_1ABC);
    endtask

    task automatic t_inval();
        fill(20'h00077, 8'd1, 20'h22222, 3'b001, 1'b0);
        fill(20'h00077, 8'd2, 20'h33333, 3'b001, 1'b0);
        expect_hit("R7 before inval", 32'h0007_7004, 8'd2, 2'd0, 32'h3333_3004);
        inval(20'h00077);
        expect_miss("R7 asid1 dropped", 32'h0007_7004, 8'd1);
        expect_miss("R7 asid2 dropped", 32'h0007_7004, 8'd2);
        expect_hit("R7 others kept", 32'h0001_2001, 8'd3, 2'd0, 32'hABCD_E001);
    endtask

    task automatic t_flush();
        fill(20'h00100, 8'd5, 20'h01000, 3'b001, 1'b0);
        fill(20'h00101, 8'd6, 20'h01010, 3'b001, 1'b0);
        flush(1'b0, 8'd5);
        expect_miss("R8 selective drop", 32'h0010_0000, 8'd5);
        expect_hit("R8 other asid kept", 32'h0010_1020, 8'd6, 2'd0, 32'h0101_0020);
        expect_hit("R8 global kept", 32'h0005_0000, 8'd5, 2'd0, 32'h1111_1000);
        flush(1'b1, 8'd0);
        expect_miss("R8 flush all global", 32'h0005_0000, 8'd5);
        expect_miss("R8 flush all other", 32'h0010_1020, 8'd6);
    endtask

    task automatic t_collide();
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h00200; fill_asid = 8'd1;
        fill_pfn = 20'h02000; fill_perm = 3'b001; fill_global = 1'b0;
        inv_valid = 1'b1; inv_vpn = 20'h00999;
        @(negedge clk);
        fill_valid = 1'b0; inv_valid = 1'b0;
        expect_miss("R9 fill lost to inval", 32'h0020_0000, 8'd1);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h00201; fill_asid = 8'd1;
        fill_pfn = 20'h02010; fill_perm = 3'b001; fill_global = 1'b0;
        lk_valid = 1'b1; lk_vaddr = 32'h0020_1008; lk_asid = 8'd1; lk_kind = 2'd0;
        @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        nfills++;
        sample();
        chk("R9 lookup sees old table", {29'd0, r_hit, r_fault, r_walk}, 32'b001);
        expect_hit("R9 later lookup", 32'h0020_1008, 8'd1, 2'd0, 32'h0201_0008);
    endtask

    task automatic t_replace();
        int s;
        int n;
        logic [19:0] victim;
        logic [19:0] nb;
        flush(1'b1, 8'd0);
        for (int i = 0; i < 64; i++) fill(20'h00400 + 20'(i), 8'd1, 20'h00800 + 20'(i), 3'b111, 1'b0);
        inval(20'h0040A);
        fill(20'h004F0, 8'd1, 20'h008F0, 3'b111, 1'b0);
        expect_hit("R10 first free slot used", 32'h004F_0000, 8'd1, 2'd0, 32'h008F_0000);
        s = nfills % 64;
        victim = (s == 10) ? 20'h004F0 : 20'h00400 + 20'(s);
        fill(20'h004F1, 8'd1, 20'h008F1, 3'b111, 1'b0);
        expect_miss("R10 pointer victim", {victim, 12'h000}, 8'd1);
        expect_hit("R10 new entry", 32'h004F_1000, 8'd1, 2'd0, 32'h008F_1000);
        n = (s + 1) % 64;
        nb = (n == 10) ? 20'h004F0 : 20'h00400 + 20'(n);
        expect_hit("R10 neighbour kept", {nb, 12'h000}, 8'd1, 2'd0, {20'h00800 + 20'(n == 10 ? 32'hF0 : n), 12'h000});
        fill(20'h004F2, 8'd1, 20'h008F2, 3'b111, 1'b0);
        expect_miss("R10 pointer advanced", {nb, 12'h000}, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_fill();
        t_perm();
        t_asid();
        t_inval();
        t_flush();
        t_collide();
        t_replace();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule